// File: doc/BRIEF.md
# Multi-mode status register bank

A bank of software-visible 32-bit registers in which every register is given an access type by a parameter. The types cover several kinds of register: hardware status that is sampled or passed straight through, sticky flags that latch on a level or capture an edge, interrupt enables, a register that captures its input once after reset, and write strobes. Flags are cleared in one of two ways: the read itself clears them, or software writes 1s to the bits it wants cleared.

Software reaches the bank through a synchronous port with word address, read enable, write enable, write data and registered read data. The hardware side presents one 32-bit input word per register and receives one 32-bit output word per register. An output word carries the value of an enable register, the captured value of a capture-after-reset register, or the one-clock pulse of a strobe register. Each flag register may be paired with the interrupt-enable register at the next address up. The bank raises a single registered interrupt when any flag bit and its enable bit are both 1.

The type of register `r` is held in `MODES[4r+3:4r]`. The codes are: 0 unmapped, 1 sampled status, 2 pass-through status, 3 level-high self-clear, 4 level-low self-clear, 5 level-high mask-clear, 6 level-low mask-clear, 7 rising-edge self-clear, 8 falling-edge self-clear, 9 rising-edge mask-clear, 10 falling-edge mask-clear, 11 interrupt enable, 12 capture-after-reset, 13 write strobe. The default map for addresses 0 to 15 is 1, 2, 3, 4, 5, 6, 7, 11, 8, 9, 11, 10, 12, 13, 0, 0. Addresses 16 to 31 are unmapped.

Top module: `stat_bank`

## Requirements
- R1: A sampled-status register (code 1) reads the value its hardware input had one clock before the read edge. Writes to it change nothing.
- R2: A pass-through register (code 2) returns on `reg_rdata` the hardware input present at the edge where the read is accepted. Read data always appears after the accepting edge and holds until the next read.
- R3: A level flag bit (codes 3 to 6) becomes 1 at any edge where its input is at the active level: 1 for codes 3 and 5, 0 for codes 4 and 6. The bit then stays 1 until it is cleared.
- R4: An edge flag bit (codes 7 to 10) becomes 1 only at an edge where its input differs from its value at the previous edge. Codes 7 and 9 respond to 0 to 1 and codes 8 and 10 respond to 1 to 0. The first edge after reset captures nothing, and an input held steady sets nothing.
- R5: A read of a self-clearing flag register (codes 3, 4, 7, 8) returns the value held before the read and then clears it. Writes to such a register are ignored.
- R6: A write to a mask-clearing flag register (codes 5, 6, 9, 10) clears the bits written with 1 and leaves the bits written with 0 unchanged. Reads of such a register do not clear it.
- R7: When a set condition and a clear land on the same bit at the same edge, the bit stays 1.
- R8: An interrupt-enable register (code 11) is plain read/write and drives its value on its output word. `irq` becomes 1 one clock after any bit is 1 both in a flag register and in a code-11 register at the next address up.
- R9: A capture-after-reset register (code 12) takes its hardware input at the first edge after reset is released. After that it behaves as plain read/write and drives its value on its output word.
- R10: A write to a strobe register (code 13) drives the written word on its output word for exactly the one clock after the write edge. The output word is 0 at all other times, and so is the value read back.
- R11: Reads of unmapped registers (code 0, or an address of NREGS or above) return 0 and clear nothing in any register.
- R12: While reset is active, all outputs are 0: `reg_rdata`, `irq` and every output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_in | input | NREGS*DW | Hardware input word per register, register r at bits r*DW upward |
| hw_out | output | NREGS*DW | Control or strobe word per register, zero for status and flag types |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_rd | input | 1 | Read enable |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A behavioural model predicts read data, the interrupt and every output word on every clock. It runs through directed sequences and then a long random mix in which a few input bits flip per cycle while reads and writes land on mapped and unmapped addresses. The directed sequences separate related cases: a held input against a toggled one shows level flags apart from edge flags, and rising and falling steps show the two edge polarities apart. A set condition held during a clearing read confirms that the set wins. A mask write with mixed 1s and 0s shows bitwise clearing apart from whole-register clearing. A read placed directly after an input change shows the sampled register's lag apart from the pass-through path.

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int NREGS = 16,
  parameter int DW = 32,
  parameter int ADDR_W = 5,
  parameter logic [4*NREGS-1:0] MODES = 64'h00DC_AB98_B765_4321
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREGS*DW-1:0] hw_in,
  output logic [NREGS*DW-1:0] hw_out,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq
);
  localparam logic [3:0] M_NONE = 4'd0,  M_RO   = 4'd1,  M_RV   = 4'd2;
  localparam logic [3:0] M_LHSC = 4'd3,  M_LLSC = 4'd4,  M_LHMK = 4'd5;
  localparam logic [3:0] M_LLMK = 4'd6,  M_IHSC = 4'd7,  M_ILSC = 4'd8;
  localparam logic [3:0] M_IHMK = 4'd9,  M_ILMK = 4'd10, M_IEN  = 4'd11;
  localparam logic [3:0] M_LOR  = 4'd12, M_RWSC = 4'd13;

  function automatic logic [3:0] mode_of(input int i);
    if (i < NREGS) return MODES[i*4 +: 4];
    return M_NONE;
  endfunction

  logic                armed;
  logic [NREGS*DW-1:0] view_flat;
  logic [NREGS-1:0]    pend;
  logic [DW-1:0]       sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    localparam logic [3:0] M = mode_of(r);
    localparam bit FLAG = (M >= M_LHSC) && (M <= M_ILMK);
    localparam bit SC = (M == M_LHSC) || (M == M_LLSC) || (M == M_IHSC) || (M == M_ILSC);
    logic [DW-1:0] din;
    logic          hit;
    assign din = hw_in[r*DW +: DW];
    assign hit = (reg_addr == ADDR_W'(r));

    if (FLAG) begin : g_flag
      logic [DW-1:0] q, prev, set_v, clr_v;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) prev <= '0;
        else        prev <= din;
      always_comb begin
        case (M)
          M_LHSC, M_LHMK: set_v = din;
          M_LLSC, M_LLMK: set_v = ~din;
          M_IHSC, M_IHMK: set_v = din & ~prev & {DW{armed}};
          default:        set_v = ~din & prev & {DW{armed}};
        endcase
        if (SC) clr_v = {DW{reg_rd & hit}};
        else    clr_v = (reg_wr && hit) ? reg_wdata : '0;
      end
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= set_v | (q & ~clr_v);
      assign view_flat[r*DW +: DW] = q;
      assign hw_out[r*DW +: DW] = '0;
      if (mode_of(r + 1) == M_IEN) begin : g_en
        assign pend[r] = |(q & view_flat[(r+1)*DW +: DW]);
      end else begin : g_noen
        assign pend[r] = 1'b0;
      end
    end else if (M == M_RO) begin : g_ro
      logic [DW-1:0] q;
      logic unused_ro;
      assign unused_ro = hit;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= din;
      assign view_flat[r*DW +: DW] = q;
      assign hw_out[r*DW +: DW] = '0;
      assign pend[r] = 1'b0;
    end else if (M == M_RV) begin : g_rv
      logic unused_rv;
      assign unused_rv = hit;
      assign view_flat[r*DW +: DW] = din;
      assign hw_out[r*DW +: DW] = '0;
      assign pend[r] = 1'b0;
    end else if (M == M_IEN) begin : g_ien
      logic [DW-1:0] q;
      logic unused_ien;
      assign unused_ien = ^din;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)            q <= '0;
        else if (reg_wr && hit) q <= reg_wdata;
      assign view_flat[r*DW +: DW] = q;
      assign hw_out[r*DW +: DW] = q;
      assign pend[r] = 1'b0;
    end else if (M == M_LOR) begin : g_lor
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)             q <= '0;
        else if (!armed)        q <= din;
        else if (reg_wr && hit) q <= reg_wdata;
      assign view_flat[r*DW +: DW] = q;
      assign hw_out[r*DW +: DW] = q;
      assign pend[r] = 1'b0;
    end else if (M == M_RWSC) begin : g_rwsc
      logic [DW-1:0] q;
      logic unused_rwsc;
      assign unused_rwsc = ^din;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= (reg_wr && hit) ? reg_wdata : '0;
      assign view_flat[r*DW +: DW] = q;
      assign hw_out[r*DW +: DW] = q;
      assign pend[r] = 1'b0;
    end else begin : g_none
      logic unused_none;
      assign unused_none = ^{din, hit};
      assign view_flat[r*DW +: DW] = '0;
      assign hw_out[r*DW +: DW] = '0;
      assign pend[r] = 1'b0;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREGS; i++)
      if (reg_addr == ADDR_W'(i)) sel = view_flat[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pend;
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int NREGS = 16,
  parameter int DW = 32,
  parameter int ADDR_W = 5,
  parameter logic [4*NREGS-1:0] MODES = 64'h00DC_AB98_B765_4321
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NREGS*DW-1:0] hw_in,
  input logic [NREGS*DW-1:0] hw_out,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_rd,
  input logic                reg_wr,
  input logic [DW-1:0]       reg_wdata,
  input logic [DW-1:0]       reg_rdata,
  input logic                irq,
  input logic [NREGS*DW-1:0] view_flat
);
  function automatic logic [3:0] mode_of(input int i);
    if (i < NREGS) return MODES[i*4 +: 4];
    return 4'd0;
  endfunction

  logic up, unmapped, unused_chk;
  assign unused_chk = irq;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;

  always_comb begin
    unmapped = 1'b1;
    for (int i = 0; i < NREGS; i++)
      if (reg_addr == ADDR_W'(i) && mode_of(i) != 4'd0) unmapped = 1'b0;
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && unmapped) |=> (reg_rdata == '0)); // R11

  for (genvar r = 0; r < NREGS; r++) begin : g_chk
    localparam logic [3:0] M = mode_of(r);
    if (M == 4'd1) begin : g_ro
      AST_RO_LAGS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (view_flat[r*DW +: DW] == $past(hw_in[r*DW +: DW]))); // R1
    end else if (M == 4'd3 || M == 4'd5) begin : g_lh
      AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> ((view_flat[r*DW +: DW] & $past(hw_in[r*DW +: DW])) == $past(hw_in[r*DW +: DW]))); // R3
    end else if (M == 4'd4 || M == 4'd6) begin : g_ll
      AST_LEVEL_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> ((view_flat[r*DW +: DW] & ~$past(hw_in[r*DW +: DW])) == ~$past(hw_in[r*DW +: DW]))); // R3
    end else if (M == 4'd11) begin : g_ien
      AST_ENABLE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(reg_wr && reg_addr == ADDR_W'(r))) |-> (hw_out[r*DW +: DW] == $past(reg_wdata))); // R8
    end else if (M == 4'd13) begin : g_rwsc
      AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (hw_out[r*DW +: DW] == ($past(reg_wr && reg_addr == ADDR_W'(r)) ? $past(reg_wdata) : '0))); // R10
    end
  end
endmodule

bind stat_bank stat_bank_chk #(.NREGS(NREGS), .DW(DW), .ADDR_W(ADDR_W), .MODES(MODES)) u_chk (.*);

// File: tb/stat_bank_tb.sv
module stat_bank_tb;
  localparam int NR = 16, DW = 32, AW = 5;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rd, wr, irq;
  logic [NR*DW-1:0] hw_in, hw_out;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, rdata;

  stat_bank u_dut (.clk(clk), .rst_n(rst_n), .hw_in(hw_in), .hw_out(hw_out),
    .reg_addr(addr), .reg_rd(rd), .reg_wr(wr), .reg_wdata(wd),
    .reg_rdata(rdata), .irq(irq));

  int modes [NR] = '{1, 2, 3, 4, 5, 6, 7, 11, 8, 9, 11, 10, 12, 13, 0, 0};
  logic [DW-1:0] mq [NR];
  logic [DW-1:0] mprev [NR];
  logic [DW-1:0] mr;
  bit marm, mirq;
  int last_mode, checks, fails;

  function automatic string tag(int m);
    case (m)
      1: return "R1";
      2: return "R2";
      3, 4, 7, 8: return "R5";
      5, 6, 9, 10: return "R6";
      11: return "R8";
      12: return "R9";
      13: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [DW-1:0] hin(int r);
    return hw_in[r*DW +: DW];
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [DW-1:0] nq [NR];
    logic [DW-1:0] sv, cv, d;
    bit hw, hr, nirq;
    if (rd) begin
      int a = int'(addr);
      last_mode = (a < NR) ? modes[a] : 0;
      if (a >= NR || modes[a] == 0) mr = '0;
      else if (modes[a] == 2)       mr = hin(a);
      else                          mr = mq[a];
    end
    nirq = 1'b0;
    for (int r = 0; r + 1 < NR; r++)
      if (modes[r] >= 3 && modes[r] <= 10 && modes[r+1] == 11 && (mq[r] & mq[r+1]) != '0)
        nirq = 1'b1;
    for (int r = 0; r < NR; r++) begin
      d = hin(r);
      hw = wr && int'(addr) == r;
      hr = rd && int'(addr) == r;
      nq[r] = mq[r];
      sv = '0;
      case (modes[r])
        1: nq[r] = d;
        3, 5: sv = d;
        4, 6: sv = ~d;
        7, 9: sv = marm ? (d & ~mprev[r]) : '0;
        8, 10: sv = marm ? (~d & mprev[r]) : '0;
        11: if (hw) nq[r] = wd;
        12: nq[r] = !marm ? d : (hw ? wd : mq[r]);
        13: nq[r] = hw ? wd : '0;
        default: ;
      endcase
      if (modes[r] >= 3 && modes[r] <= 10) begin
        if (modes[r] == 3 || modes[r] == 4 || modes[r] == 7 || modes[r] == 8)
          cv = hr ? '1 : '0;
        else
          cv = hw ? wd : '0;
        nq[r] = sv | (mq[r] & ~cv);
      end
    end
    for (int r = 0; r < NR; r++) begin
      mq[r] = nq[r];
      mprev[r] = hin(r);
    end
    marm = 1'b1;
    mirq = nirq;
  endtask

  task automatic compare_all();
    chk(rdata, mr, tag(last_mode), "rdata");
    chk({31'd0, irq}, {31'd0, mirq}, "R8", "irq");
    for (int r = 0; r < NR; r++)
      chk(hw_out[r*DW +: DW], (modes[r] >= 11 && modes[r] <= 13) ? mq[r] : '0,
          tag(modes[r]), $sformatf("hw_out[%0d]", r));
  endtask

  task automatic cyc(input int a, input bit r, input bit w, input logic [DW-1:0] d);
    addr = AW'(a); rd = r; wr = w; wd = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, 1'b0, 1'b0, '0); endtask
  task automatic rdr(input int a); cyc(a, 1'b1, 1'b0, '0); endtask
  task automatic wrr(input int a, input logic [DW-1:0] d); cyc(a, 1'b0, 1'b1, d); endtask
  task automatic seti(input int r, input logic [DW-1:0] v); hw_in[r*DW +: DW] = v; endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; last_mode = 0; mr = '0; marm = 0; mirq = 0;
    for (int r = 0; r < NR; r++) begin mq[r] = '0; mprev[r] = '0; end
    rst_n = 1'b0; rd = 0; wr = 0; addr = '0; wd = '0; hw_in = '0;
    seti(12, 32'hA5A5_0F0F);
    seti(3, 32'hFFFF_FFFF);
    seti(6, 32'h0);
    repeat (3) @(negedge clk);
    chk(rdata, '0, "R12", "rdata in reset");
    chk({31'd0, irq}, '0, "R12", "irq in reset");
    for (int r = 0; r < NR; r++) chk(hw_out[r*DW +: DW], '0, "R12", "hw_out in reset");
    rst_n = 1'b1;
    idle();
    chk(hw_out[12*DW +: DW], 32'hA5A5_0F0F, "R9", "capture after reset");
    seti(12, 32'h1111_2222);
    idle();
    rdr(12);
    chk(rdata, 32'hA5A5_0F0F, "R9", "capture held");
    wrr(12, 32'h0000_00C3);
    rdr(12);
    chk(rdata, 32'h0000_00C3, "R9", "rw after capture");

    seti(0, 32'h1234_5678); idle();
    wrr(0, 32'hFFFF_FFFF);
    seti(0, 32'h8765_4321);
    rdr(0);
    chk(rdata, 32'h1234_5678, "R1", "lag and write ignored");
    rdr(0);
    chk(rdata, 32'h8765_4321, "R1", "sampled");

    seti(1, 32'hCAFE_0001);
    rdr(1);
    chk(rdata, 32'hCAFE_0001, "R2", "pass-through");

    seti(2, 32'h1); idle();
    rdr(2); chk(rdata, 32'h1, "R7", "set held while read");
    rdr(2); chk(rdata, 32'h1, "R7", "set wins over read clear");
    seti(2, 32'h0); rdr(2);
    rdr(2); chk(rdata, 32'h0, "R5", "cleared by read");
    seti(2, 32'h4); idle(); seti(2, 32'h0);
    rdr(20); chk(rdata, '0, "R11", "high address");
    rdr(14); chk(rdata, '0, "R11", "unmapped slot");
    rdr(2); chk(rdata, 32'h4, "R11", "no clear on unmapped read");
    rdr(2); chk(rdata, 32'h0, "R3", "sticky then cleared");
    wrr(2, 32'hFFFF_FFFF);
    seti(3, 32'hFFFF_FFFE); idle(); seti(3, 32'hFFFF_FFFF);
    rdr(3); rdr(3); rdr(3);
    chk(rdata, 32'h0, "R3", "low level cleared");

    seti(4, 32'h0000_00F0); idle(); seti(4, 32'h0);
    wrr(4, 32'h0000_0030);
    rdr(4); chk(rdata, 32'h0000_00C0, "R6", "mask clear");
    rdr(4); chk(rdata, 32'h0000_00C0, "R6", "read does not clear");

    wrr(7, 32'h1);
    seti(6, 32'h1); idle();
    chk({31'd0, irq}, '0, "R8", "irq not yet");
    idle();
    chk({31'd0, irq}, 32'h1, "R8", "irq raised");
    rdr(6); chk(rdata, 32'h1, "R4", "rising captured");
    idle(); chk({31'd0, irq}, '0, "R8", "irq dropped");
    rdr(6); chk(rdata, 32'h0, "R4", "steady level no capture");
    seti(8, 32'h2); idle(); seti(8, 32'h0); idle();
    rdr(8); chk(rdata, 32'h2, "R4", "falling captured");

    wrr(13, 32'h0000_0005);
    chk(hw_out[13*DW +: DW], 32'h5, "R10", "strobe pulse");
    idle();
    chk(hw_out[13*DW +: DW], 32'h0, "R10", "strobe ended");
    rdr(13); chk(rdata, 32'h0, "R10", "strobe reads zero");

    for (int i = 0; i < 4000; i++) begin
      int rr = $urandom_range(0, NR - 1);
      int bb = $urandom_range(0, DW - 1);
      if ($urandom_range(0, 1) == 1) hw_in[rr*DW + bb] = ~hw_in[rr*DW + bb];
      cyc($urandom_range(0, 31), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), $urandom());
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule